// File: doc/BRIEF.md
# CAN Error Confinement and Status Tracker

This block keeps the fault-confinement state of a CAN node. The protocol engine sends it single-cycle pulses: an error pulse carrying a 3-bit error class and a flag saying whether the node was sending at the time, a pulse for each frame sent cleanly, a pulse for each frame received cleanly, and a pulse when the bus-off recovery sequence has finished. From these it keeps a 9-bit transmit error counter and an 8-bit receive error counter. It derives the warning, error-passive and bus-off flags from the counters with comparators only.

An 8-bit status word gives software the flags and a last-error code. Software may write the code field through a one-cycle write strobe. Writing the unused value 7 leaves a marker. Every later update by hardware overwrites it, so software can tell that the field has been refreshed. While the node is bus-off it ignores all traffic pulses until the recovery pulse arrives.

Top module: `can_err_confine`

## Requirements
- R1: After reset the status word, the transmit counter and the receive counter all read 0.
- R2: A valid error pulse with the transmit flag set adds 8 to the transmit counter. With the flag clear it adds 1 to the receive counter, which holds at 255 instead of wrapping.
- R3: A clean-send pulse takes 1 from the transmit counter and a clean-receive pulse takes 1 from the receive counter, never below 0. Only one event acts per cycle, in the order valid error, then clean send, then clean receive.
- R4: Status bit 0 (warning) is 1 exactly when either counter is at or above 96.
- R5: Status bit 1 (error passive) is 1 exactly when either counter is at or above 128.
- R6: Status bit 2 (bus-off) is 1 exactly when the transmit counter is above 255. The receive counter never causes it.
- R7: While bus-off, error, clean-send and clean-receive pulses change neither counter nor the code. A recovery pulse while bus-off clears both counters, and with them all three flags. A recovery pulse outside bus-off has no effect.
- R8: A valid error pulse loads its class into status bits 6:4 (1 stuff, 2 form, 3 acknowledge, 4 recessive-bit, 5 dominant-bit, 6 CRC). An error pulse whose class is 0 or 7 is ignored entirely.
- R9: A clean-send or clean-receive pulse that acts (R3, R7) sets status bits 6:4 to 0.
- R10: A software write stores any 3-bit value, including 7, into bits 6:4. A hardware update of the field in the same cycle takes precedence. Status bits 7 and 3 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| err_stb | input | 1 | One-cycle pulse: an error was detected |
| err_class | input | 3 | Error class for err_stb |
| err_while_tx | input | 1 | 1: the error occurred while sending, 0: while receiving |
| tx_done | input | 1 | One-cycle pulse: a frame was sent without error |
| rx_done | input | 1 | One-cycle pulse: a frame was received without error |
| recov_done | input | 1 | One-cycle pulse: bus-off recovery sequence finished |
| code_wr | input | 1 | Software write strobe for the error-code field |
| code_wdata | input | 3 | Value written by software |
| status | output | 8 | {0, code[2:0], 0, bus-off, error-passive, warning} |
| tx_err_cnt | output | 9 | Transmit error counter |
| rx_err_cnt | output | 8 | Receive error counter |

## Verification
The bench walks both counters across every flag threshold one step at a time. A comparator off by one (> against >=) or testing the wrong counter therefore flips a flag one event early or late. It drives the transmit counter from 248 to 256 and then sends traffic while bus-off. A design that lets the counter wrap, or that still counts while bus-off, would clear the bus-off flag or change the counters there. It also applies colliding pulses in one cycle, hardware and software code updates in one cycle, a software marker of 7 followed by an error, error classes 0 and 7, and recovery outside bus-off. Each of these shows a wrong priority or a missing guard as a wrong code or a wrong counter value.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
  localparam int TEC_W     = 9;
  localparam int REC_W     = 8;
  localparam int CODE_W    = 3;
  localparam int TX_STEP   = 8;
  localparam int RX_STEP   = 1;
  localparam int WARN_LIM  = 96;
  localparam int PASS_LIM  = 128;
  localparam int BOFF_LIM  = 256;

  typedef enum logic [CODE_W-1:0] {
    CODE_NONE  = 3'd0,
    CODE_STUFF = 3'd1,
    CODE_FORM  = 3'd2,
    CODE_ACK   = 3'd3,
    CODE_REC1  = 3'd4,
    CODE_DOM0  = 3'd5,
    CODE_CRC   = 3'd6,
    CODE_MARK  = 3'd7
  } err_code_e;

  function automatic logic code_is_hw(input logic [CODE_W-1:0] c);
    return (c != CODE_NONE) && (c != CODE_MARK);
  endfunction
endpackage

// File: rtl/can_err_rstsync.sv
module can_err_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      stage1  <= 1'b1;
      rst_q_n <= stage1;
    end
  end
endmodule

// File: rtl/can_err_ctr.sv
module can_err_ctr #(
  parameter int W    = 8,
  parameter int STEP = 1,
  parameter int CAP  = 255
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt
);
  localparam logic [W:0] CAP_X  = (W+1)'(CAP);
  localparam logic [W:0] STEP_X = (W+1)'(STEP);

  logic [W:0]   sum;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    sum    = {1'b0, cnt} + STEP_X;
    cnt_d  = cnt;
    cnt_en = 1'b0;
    if (clr) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (inc) begin
      cnt_d  = (sum > CAP_X) ? CAP_X[W-1:0] : sum[W-1:0];
      cnt_en = 1'b1;
    end else if (dec && (cnt != '0)) begin
      cnt_d  = cnt - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/can_err_flags.sv
module can_err_flags #(
  parameter int TW   = 9,
  parameter int RW   = 8,
  parameter int WARN = 96,
  parameter int PASS = 128,
  parameter int BOFF = 256
) (
  input  logic [TW-1:0] tec,
  input  logic [RW-1:0] rec,
  output logic          warn,
  output logic          passive,
  output logic          bus_off
);
  int tec_i, rec_i;

  always_comb begin
    tec_i   = int'(tec);
    rec_i   = int'(rec);
    warn    = (tec_i >= WARN) || (rec_i >= WARN);
    passive = (tec_i >= PASS) || (rec_i >= PASS);
    bus_off = (tec_i >= BOFF);
  end
endmodule

// File: rtl/can_err_code.sv
module can_err_code #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_load,
  input  logic [CW-1:0] hw_code,
  input  logic          hw_clr,
  input  logic          sw_wr,
  input  logic [CW-1:0] sw_code,
  output logic [CW-1:0] code
);
  logic [CW-1:0] code_d;
  logic          code_en;

  always_comb begin
    code_d  = code;
    code_en = 1'b1;
    if (hw_load)     code_d = hw_code;
    else if (hw_clr) code_d = '0;
    else if (sw_wr)  code_d = sw_code;
    else             code_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code <= '0;
    else if (code_en) code <= code_d;
  end
endmodule

// File: rtl/can_err_confine.sv
module can_err_confine
  import can_err_pkg::*;
#(
  parameter int TW = TEC_W,
  parameter int RW = REC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          err_stb,
  input  logic [2:0]    err_class,
  input  logic          err_while_tx,
  input  logic          tx_done,
  input  logic          rx_done,
  input  logic          recov_done,
  input  logic          code_wr,
  input  logic [2:0]    code_wdata,
  output logic [7:0]    status,
  output logic [TW-1:0] tx_err_cnt,
  output logic [RW-1:0] rx_err_cnt
);
  localparam int TEC_CAP = (1 << TW) - 1;
  localparam int REC_CAP = (1 << RW) - 1;

  logic       rst_q_n;
  logic       warn, passive, bus_off;
  logic       live, err_ok, tx_ok_act, rx_ok_act, recov_ok;
  logic [2:0] code;

  can_err_rstsync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  always_comb begin
    live      = !bus_off;
    err_ok    = live && err_stb && code_is_hw(err_class);
    tx_ok_act = live && !err_ok && tx_done;
    rx_ok_act = live && !err_ok && !tx_done && rx_done;
    recov_ok  = bus_off && recov_done;
  end

  can_err_ctr #(.W(TW), .STEP(TX_STEP), .CAP(TEC_CAP)) u_tec (
    .clk(clk), .rst_n(rst_q_n), .clr(recov_ok),
    .inc(err_ok && err_while_tx), .dec(tx_ok_act), .cnt(tx_err_cnt)
  );

  can_err_ctr #(.W(RW), .STEP(RX_STEP), .CAP(REC_CAP)) u_rec (
    .clk(clk), .rst_n(rst_q_n), .clr(recov_ok),
    .inc(err_ok && !err_while_tx), .dec(rx_ok_act), .cnt(rx_err_cnt)
  );

  can_err_flags #(.TW(TW), .RW(RW), .WARN(WARN_LIM), .PASS(PASS_LIM), .BOFF(BOFF_LIM)) u_flags (
    .tec(tx_err_cnt), .rec(rx_err_cnt),
    .warn(warn), .passive(passive), .bus_off(bus_off)
  );

  can_err_code #(.CW(CODE_W)) u_code (
    .clk(clk), .rst_n(rst_q_n),
    .hw_load(err_ok), .hw_code(err_class),
    .hw_clr(tx_ok_act || rx_ok_act),
    .sw_wr(code_wr), .sw_code(code_wdata),
    .code(code)
  );

  assign status = {1'b0, code, 1'b0, bus_off, passive, warn};
endmodule

// File: rtl/can_err_confine_chk.sv
module can_err_confine_chk #(
  parameter int TW = 9,
  parameter int RW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          err_stb,
  input logic [2:0]    err_class,
  input logic          err_while_tx,
  input logic          tx_done,
  input logic          recov_done,
  input logic          code_wr,
  input logic [7:0]    status,
  input logic [TW-1:0] tx_err_cnt,
  input logic [RW-1:0] rx_err_cnt
);
  logic valid_err;
  assign valid_err = err_stb && (err_class != 3'd0) && (err_class != 3'd7);

  // R2: a valid transmit-side error adds exactly 8
  p_tx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[2] && valid_err && err_while_tx) |=> (tx_err_cnt == $past(tx_err_cnt) + TW'(8)));

  // R6: bus-off always implies error passive
  p_boff_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] |-> status[1]);

  // R7: counters frozen while bus-off unless recovery arrives
  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status[2] && !recov_done) |=> ($stable(tx_err_cnt) && $stable(rx_err_cnt)));

  // R7: recovery in bus-off clears both counters
  p_recover_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status[2] && recov_done) |=> (tx_err_cnt == '0 && rx_err_cnt == '0));

  // R9: an acting clean send clears the code
  p_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[2] && tx_done && !valid_err) |=> (status[6:4] == 3'd0));

  // R10: the marker value 7 only appears after a software write
  p_mark_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!code_wr && status[6:4] != 3'd7) |=> (status[6:4] != 3'd7));

  // R10: reserved bits stay 0
  p_rsvd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] == 1'b0) && (status[3] == 1'b0));
endmodule

bind can_err_confine can_err_confine_chk #(.TW(TW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .err_stb(err_stb), .err_class(err_class),
  .err_while_tx(err_while_tx), .tx_done(tx_done), .recov_done(recov_done),
  .code_wr(code_wr), .status(status), .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt)
);

// File: tb/can_err_confine_bench.sv
module can_err_confine_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       err_stb = 1'b0, err_while_tx = 1'b0, tx_done = 1'b0, rx_done = 1'b0;
  logic       recov_done = 1'b0, code_wr = 1'b0;
  logic [2:0] err_class = 3'd0, code_wdata = 3'd0;
  logic [7:0] status;
  logic [8:0] tx_err_cnt;
  logic [7:0] rx_err_cnt;

  int n_run = 0, n_fail = 0;
  int m_tec = 0, m_rec = 0, m_code = 0;
  bit started = 0;

  always #4 clk = ~clk;

  can_err_confine u_can_err_confine (
    .clk(clk), .rst_n(rst_n), .err_stb(err_stb), .err_class(err_class),
    .err_while_tx(err_while_tx), .tx_done(tx_done), .rx_done(rx_done),
    .recov_done(recov_done), .code_wr(code_wr), .code_wdata(code_wdata),
    .status(status), .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt)
  );

  // behavioural reference model
  always @(posedge clk) begin
    bit boff, valid, hw_code;
    if (!rst_n) begin
      m_tec = 0; m_rec = 0; m_code = 0;
    end else begin
      boff = (m_tec > 255);
      valid = err_stb && err_class != 0 && err_class != 7;
      hw_code = 0;
      if (boff) begin
        if (recov_done) begin m_tec = 0; m_rec = 0; end
      end else if (valid) begin
        hw_code = 1; m_code = err_class;
        if (err_while_tx) m_tec += 8;
        else if (m_rec < 255) m_rec += 1;
      end else if (tx_done) begin
        hw_code = 1; m_code = 0;
        if (m_tec > 0) m_tec -= 1;
      end else if (rx_done) begin
        hw_code = 1; m_code = 0;
        if (m_rec > 0) m_rec -= 1;
      end
      if (code_wr && !hw_code) m_code = code_wdata;
    end
  end

  function automatic int exp_status();
    int s;
    s = m_code << 4;
    if (m_tec > 255) s |= 4;
    if (m_tec >= 128 || m_rec >= 128) s |= 2;
    if (m_tec >= 96 || m_rec >= 96) s |= 1;
    return s;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R2..R10 status/counters)
  always @(negedge clk) if (started) begin
    chk("R2 tx counter vs model", int'(tx_err_cnt), m_tec);
    chk("R3 rx counter vs model", int'(rx_err_cnt), m_rec);
    chk("R10 status vs model", int'(status), exp_status());
  end

  task automatic drive(bit e, int cls, bit tx, bit tok, bit rok, bit rcv, bit wr, int wd);
    @(negedge clk);
    err_stb = e; err_class = 3'(cls); err_while_tx = tx;
    tx_done = tok; rx_done = rok; recov_done = rcv;
    code_wr = wr; code_wdata = 3'(wd);
    @(negedge clk);
    err_stb = 0; tx_done = 0; rx_done = 0; recov_done = 0; code_wr = 0;
  endtask

  task automatic rx_errs(int n, int cls);
    for (int i = 0; i < n; i++) drive(1, cls, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic tx_errs(int n, int cls);
    for (int i = 0; i < n; i++) drive(1, cls, 1, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 150000);
    chk("watchdog expired", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    started = 1;
    chk("R1 reset status", int'(status), 0);
    chk("R1 reset tx counter", int'(tx_err_cnt), 0);
    chk("R1 reset rx counter", int'(rx_err_cnt), 0);

    rx_errs(95, 1);
    chk("R4 warning off at 95", int'(status[0]), 0);
    rx_errs(1, 1);
    chk("R4 warning on at 96", int'(status[0]), 1);
    chk("R8 code stuff", int'(status[6:4]), 1);
    rx_errs(31, 3);
    chk("R5 passive off at 127", int'(status[1]), 0);
    rx_errs(1, 3);
    chk("R5 passive on at 128", int'(status[1]), 1);
    chk("R2 rx counter 128", int'(rx_err_cnt), 128);
    drive(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R3 rx decrement", int'(rx_err_cnt), 127);
    chk("R9 clean receive clears code", int'(status[6:4]), 0);

    drive(0, 0, 0, 0, 0, 0, 1, 7);
    chk("R10 software marker 7", int'(status[6:4]), 7);
    rx_errs(1, 6);
    chk("R8 crc code replaces marker", int'(status[6:4]), 6);
    drive(1, 7, 0, 0, 0, 0, 0, 0);
    chk("R8 class 7 ignored counter", int'(rx_err_cnt), 128);
    chk("R8 class 7 ignored code", int'(status[6:4]), 6);
    drive(1, 0, 1, 0, 0, 0, 0, 0);
    chk("R8 class 0 ignored", int'(tx_err_cnt), 0);
    drive(1, 2, 0, 0, 0, 0, 1, 3);
    chk("R10 hardware wins over write", int'(status[6:4]), 2);

    drive(1, 5, 1, 1, 0, 0, 0, 0);
    chk("R3 error beats clean send", int'(tx_err_cnt), 8);
    chk("R8 dominant code", int'(status[6:4]), 5);
    drive(0, 0, 0, 1, 1, 0, 0, 0);
    chk("R3 send beats receive tx", int'(tx_err_cnt), 7);
    chk("R3 send beats receive rx", int'(rx_err_cnt), 129);
    for (int i = 0; i < 140; i++) drive(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R3 rx floor at 0", int'(rx_err_cnt), 0);
    for (int i = 0; i < 10; i++) drive(0, 0, 0, 1, 0, 0, 0, 0);
    chk("R3 tx floor at 0", int'(tx_err_cnt), 0);

    tx_errs(11, 4);
    chk("R4 tx warning off at 88", int'(status[0]), 0);
    tx_errs(1, 4);
    chk("R4 tx warning on at 96", int'(status[0]), 1);
    tx_errs(3, 4);
    chk("R5 tx passive off at 120", int'(status[1]), 0);
    tx_errs(1, 4);
    chk("R5 tx passive on at 128", int'(status[1]), 1);
    tx_errs(15, 4);
    chk("R6 bus-off clear at 248", int'(status[2]), 0);
    tx_errs(1, 2);
    chk("R6 bus-off set at 256", int'(status[2]), 1);
    chk("R6 tx counter 256", int'(tx_err_cnt), 256);
    chk("R10 reserved bits", int'({status[7], status[3]}), 0);

    drive(1, 1, 0, 0, 0, 0, 0, 0);
    drive(1, 1, 1, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 1, 0, 0, 0);
    chk("R7 tx frozen in bus-off", int'(tx_err_cnt), 256);
    chk("R7 rx frozen in bus-off", int'(rx_err_cnt), 0);
    chk("R7 code kept in bus-off", int'(status[6:4]), 2);
    drive(0, 0, 0, 0, 0, 0, 1, 5);
    chk("R10 write in bus-off", int'(status[6:4]), 5);
    drive(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R7 recovery clears counter", int'(tx_err_cnt), 0);
    chk("R7 recovery clears flags", int'(status[2:0]), 0);
    tx_errs(1, 3);
    drive(0, 0, 0, 0, 0, 1, 0, 0);
    chk("R7 recovery ignored outside bus-off", int'(tx_err_cnt), 8);

    rx_errs(260, 1);
    chk("R2 rx saturates at 255", int'(rx_err_cnt), 255);
    chk("R6 rx never bus-off", int'(status[2]), 0);

    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule